// File: doc/BRIEF.md
# Priority Arbiter for DMA Channels

This block decides which of several DMA channels may drive the shared master bus next. Every channel presents a request line together with an enable line and a suspend line. Each channel also has a small urgency value, which software loads through a one-word write port. When the bus is free, the arbiter looks only at channels that are requesting, enabled and not suspended. It picks the one with the numerically smallest urgency value, where 0 is the most urgent. If two such channels hold the same value, the lower channel number wins. The winner is presented both as a one-hot vector and as a binary index, together with a valid flag.

A grant is a lock on the bus. Once it is issued it does not move, whatever happens to requests, masks or urgency values, until the owning channel signals the end of its transaction on the done input. The grant drops on that clock edge. The next decision is made on the edge after it, using the requests and urgency values present at that time. This gives a single idle cycle between bus owners.

Top module: `dma_chan_arbiter`

## Requirements
- R1: An active-low reset clears the grant vector, the index and the valid flag, and sets every channel's urgency value to 0.
- R2: Among eligible channels, the grant goes to the channel whose urgency value is numerically smallest. Urgency value 0 is the most urgent.
- R3: When eligible channels share the smallest urgency value, the grant goes to the lowest channel index.
- R4: When all urgency values are equal (including the reset value of 0), the lowest-numbered eligible channel wins.
- R5: A channel whose suspend bit is 1 is never given a new grant.
- R6: A channel whose enable bit is 0 is never given a new grant.
- R7: While a grant is active and done_i is 0, the grant vector and the index stay unchanged, whatever happens to requests, masks or urgency values.
- R8: A 1 on done_i while a grant is active clears the grant at that clock edge. The next grant can appear no earlier than the following edge.
- R9: With no eligible channel, the grant vector is all zeros, grant_idx_o is 0 and grant_valid_o is 0.
- R10: A write to an urgency value (wr_en_i=1, with wr_chan_i selecting the channel and wr_prio_i the value) is stored at the clock edge. It never alters an active grant, and it is used by every decision made after that edge.
- R11: When grant_valid_o is 1, grant_o has exactly one bit set, at the position given by grant_idx_o (bit i means channel i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | Per-channel request, bit i for channel i |
| enable_i | input | NUM_CH | Per-channel enable; 0 masks the request |
| suspend_i | input | NUM_CH | Per-channel suspend; 1 masks the request |
| done_i | input | 1 | End-of-transaction pulse from the granted channel |
| wr_en_i | input | 1 | Urgency value write strobe |
| wr_chan_i | input | IDX_W | Channel whose urgency value is written |
| wr_prio_i | input | IDX_W | New urgency value, 0 most urgent |
| grant_o | output | NUM_CH | One-hot grant |
| grant_idx_o | output | IDX_W | Binary index of the granted channel |
| grant_valid_o | output | 1 | A grant is active |

## Verification
The hardest case to reach from the ports is an urgency write that lands while a grant is held. Its effect only becomes visible at the next decision, after the release and the idle cycle. The bench holds a grant on one channel and raises competing requests. It rewrites the urgency of one competitor mid-hold, confirms that the grant has not moved, and then releases the grant. The new winner must reflect the rewritten value. A second case is reset while urgency values are non-zero. The bench then shows that a pair of requesters falls back to index order, which proves the stored values were cleared.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dma_arb_prio_regs.sv
// Per-channel urgency storage, loaded one channel at a time.
module dma_arb_prio_regs #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_chan_i,
  input  logic [IDX_W-1:0]          wr_prio_i,
  output logic [NUM_CH*IDX_W-1:0]   prio_flat_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             ld;
    logic [IDX_W-1:0] val_q;
    logic [IDX_W-1:0] val_d;

    always_comb begin
      ld    = wr_en_i && (wr_chan_i == IDX_W'(g));
      val_d = wr_prio_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (ld) val_q <= val_d;
    end

    assign prio_flat_o[g*IDX_W +: IDX_W] = val_q;
  end
endmodule

// File: rtl/dma_arb_pick.sv
// Combinational winner selection: smallest value, lower index on ties.
module dma_arb_pick #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_CH-1:0]       elig_i,
  input  logic [NUM_CH*IDX_W-1:0] prio_flat_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [IDX_W-1:0] best_prio;

  always_comb begin
    any_o     = 1'b0;
    idx_o     = '0;
    best_prio = '0;
    // Ascending scan with strict compare keeps the lower index on ties.
    for (int i = 0; i < NUM_CH; i++) begin
      if (elig_i[i] &&
          (!any_o || (prio_flat_i[i*IDX_W +: IDX_W] < best_prio))) begin
        any_o     = 1'b1;
        idx_o     = IDX_W'(i);
        best_prio = prio_flat_i[i*IDX_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH = 8,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] enable_i,
  input  logic [NUM_CH-1:0] suspend_i,
  input  logic              done_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_chan_i,
  input  logic [IDX_W-1:0]  wr_prio_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic              grant_valid_o
);
  logic [NUM_CH*IDX_W-1:0] prio_flat;
  logic [NUM_CH-1:0]       elig;
  logic                    pick_any;
  logic [IDX_W-1:0]        pick_idx;

  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_ld;

  dma_arb_prio_regs #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) prio_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_chan_i   (wr_chan_i),
    .wr_prio_i   (wr_prio_i),
    .prio_flat_o (prio_flat)
  );

  assign elig = req_i & enable_i & ~suspend_i;

  dma_arb_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) pick_i (
    .elig_i      (elig),
    .prio_flat_i (prio_flat),
    .any_o       (pick_any),
    .idx_o       (pick_idx)
  );

  // Next-state: decide only when idle, release only on done.
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_ld  = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (pick_any) begin
          state_d = ARB_HOLD;
          idx_d   = pick_idx;
          idx_ld  = 1'b1;
        end
      end
      ARB_HOLD: begin
        if (done_i) begin
          state_d = ARB_IDLE;
          idx_d   = '0;
          idx_ld  = 1'b1;
        end
      end
      default: begin
        state_d = ARB_IDLE;
        idx_d   = '0;
        idx_ld  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_ld) idx_q <= idx_d;
  end

  always_comb begin
    grant_valid_o = (state_q == ARB_HOLD);
    grant_idx_o   = idx_q;
    grant_o       = '0;
    if (grant_valid_o) grant_o[idx_q] = 1'b1;
  end
endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter  int NUM_CH = 8,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] enable_i,
  input logic [NUM_CH-1:0] suspend_i,
  input logic              done_i,
  input logic [NUM_CH-1:0] grant_o,
  input logic [IDX_W-1:0]  grant_idx_o,
  input logic              grant_valid_o
);
  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> ($countones(grant_o) == 1) && grant_o[grant_idx_o]);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o |-> (grant_o == '0) && (grant_idx_o == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !done_i) |=>
      (grant_valid_o && $stable(grant_o) && $stable(grant_idx_o)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && done_i) |=> !grant_valid_o);

  assert_eligible_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid_o) |->
      (($past(req_i & enable_i & ~suspend_i) & grant_o) != '0));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid_o && ((req_i & enable_i & ~suspend_i) == '0)) |=>
      !grant_valid_o);
endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .enable_i      (enable_i),
  .suspend_i     (suspend_i),
  .done_i        (done_i),
  .grant_o       (grant_o),
  .grant_idx_o   (grant_idx_o),
  .grant_valid_o (grant_valid_o)
);

// File: tb/dma_chan_arbiter_tb_top.sv
module dma_chan_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int IW  = 3;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] req, en, susp;
  logic           done;
  logic           wr_en;
  logic [IW-1:0]  wr_chan, wr_prio;
  logic [NCH-1:0] grant;
  logic [IW-1:0]  gidx;
  logic           gvalid;

  int checks = 0;
  int fails  = 0;

  dma_chan_arbiter #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .enable_i(en), .suspend_i(susp),
    .done_i(done), .wr_en_i(wr_en), .wr_chan_i(wr_chan), .wr_prio_i(wr_prio),
    .grant_o(grant), .grant_idx_o(gidx), .grant_valid_o(gvalid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Urgency word: octal digit i holds channel i's value (channel 0 rightmost).
  typedef struct packed {
    logic [NCH-1:0]    req;
    logic [NCH-1:0]    susp;
    logic [NCH-1:0]    en;
    logic [NCH*IW-1:0] prio;
    logic              vld;
    logic [IW-1:0]     idx;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 8'hFF, 24'o00000000, 1'b0, 3'd0},  // R9 nothing requested
    '{8'h14, 8'h00, 8'hFF, 24'o00000000, 1'b1, 3'd2},  // R4 ch2 over ch4
    '{8'hFF, 8'h00, 8'hFF, 24'o33033333, 1'b1, 3'd5},  // R2 single urgent
    '{8'hFF, 8'h00, 8'hFF, 24'o76543210, 1'b1, 3'd0},  // R2 ascending
    '{8'hFF, 8'h00, 8'hFF, 24'o01234567, 1'b1, 3'd7},  // R2 descending
    '{8'h28, 8'h00, 8'hFF, 24'o00404000, 1'b1, 3'd3},  // R3 tie at 4
    '{8'h03, 8'h01, 8'hFF, 24'o00000000, 1'b1, 3'd1},  // R5 ch0 suspended
    '{8'h03, 8'h00, 8'hFE, 24'o00000000, 1'b1, 3'd1},  // R6 ch0 disabled
    '{8'h0F, 8'h0F, 8'hFF, 24'o00000000, 1'b0, 3'd0},  // R5 all suspended
    '{8'h90, 8'h00, 8'hFF, 24'o10020000, 1'b1, 3'd7},  // R2 ch7=1 beats ch4=2
    '{8'h90, 8'h80, 8'hFF, 24'o10020000, 1'b1, 3'd4}   // R5 urgent one suspended
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_grant(input logic exp_v, input logic [IW-1:0] exp_i,
                             input string tag);
    logic [NCH-1:0] exp_g;
    exp_g = exp_v ? (NCH'(1) << exp_i) : '0;
    checks++;
    if (gvalid !== exp_v || gidx !== exp_i || grant !== exp_g) begin
      fails++;
      $display("FAIL %s (R11 form): valid=%0b idx=%0d grant=%b expected valid=%0b idx=%0d grant=%b",
               tag, gvalid, gidx, grant, exp_v, exp_i, exp_g);
    end
  endtask

  task automatic write_prio(input int ch, input logic [IW-1:0] p);
    wr_en = 1'b1; wr_chan = IW'(ch); wr_prio = p;
    step();
    wr_en = 1'b0;
  endtask

  task automatic load_prio(input logic [NCH*IW-1:0] w);
    for (int c = 0; c < NCH; c++) write_prio(c, w[c*IW +: IW]);
  endtask

  task automatic release_all();
    done = 1'b1; req = '0;
    step();
    done = 1'b0;
    step();
  endtask

  initial begin
    rst_n = 1'b0; req = '0; en = '1; susp = '0; done = 1'b0;
    wr_en = 1'b0; wr_chan = '0; wr_prio = '0;
    @(negedge clk);
    check_grant(1'b0, '0, "R1 in reset");
    step();
    rst_n = 1'b1;
    step();
    check_grant(1'b0, '0, "R1 after reset");

    for (int v = 0; v < NV; v++) begin
      en = VECS[v].en; susp = VECS[v].susp; req = '0;
      load_prio(VECS[v].prio);
      req = VECS[v].req;
      step();
      check_grant(VECS[v].vld, VECS[v].idx, $sformatf("R2/R3/R4/R5/R6/R9 vector %0d", v));
      release_all();
    end

    // R7: hold despite more urgent newcomer and mask changes
    en = '1; susp = '0;
    load_prio(24'o00000000);
    req = 8'h08;
    step();
    check_grant(1'b1, 3'd3, "R7 initial grant");
    req = 8'h09;
    step();
    check_grant(1'b1, 3'd3, "R7 newcomer ch0");
    susp = 8'h08; req = 8'h01;
    step();
    check_grant(1'b1, 3'd3, "R7 owner suspended and dropped");
    susp = '0;

    // R10: write during hold does not move grant, used afterwards
    req = 8'h0B;
    write_prio(0, 3'd7);
    check_grant(1'b1, 3'd3, "R10 write during hold");
    done = 1'b1; req = 8'h03;
    step();
    done = 1'b0;
    check_grant(1'b0, '0, "R8 idle cycle after done");
    step();
    check_grant(1'b1, 3'd1, "R10 new value used (ch1 over ch0=7)");
    release_all();

    // R1: reset clears stored urgency values
    write_prio(3, 3'd0);
    write_prio(2, 3'd6);
    rst_n = 1'b0;
    step();
    check_grant(1'b0, '0, "R1 mid-run reset");
    rst_n = 1'b1;
    req = 8'h0C;
    step();
    check_grant(1'b1, 3'd2, "R1 urgency cleared to index order");
    release_all();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule